// File: doc/BRIEF.md
# Dual Retriggerable One-Shot Pulse Generator

This block is a clocked, counter-based pulse stretcher with two identical, independent channels. Each channel watches a pair of trigger lines. One line fires on its rising edge and the other on its falling edge. Each line is gated by the level of its partner. A qualifying edge drives the channel output high for a programmed number of clock cycles. A further qualifying edge during the pulse restarts the count, so the pulse ends a full width after the most recent trigger. Each channel drives its output together with the inverse of that output.

Each channel has an active-low clear. Holding clear low drops the output at once and blocks all triggers. When clear is released, the channel stays deaf to triggers for a fixed recovery interval before it re-arms. Trigger and clear inputs are treated as asynchronous. They pass through two synchronizing flops and an edge-history register before any decision is made. The pulse length of each channel comes from a run-time input vector.

Top module: `oneshot_dual`

## Requirements
- R1: A rise of `trig_up[i]` while `trig_dn[i]` is high and `clr_n[i]` is high is a valid trigger for channel i.
- R2: A fall of `trig_dn[i]` while `trig_up[i]` is low and `clr_n[i]` is high is a valid trigger. A fall of `trig_up`, a rise of `trig_dn`, a rise of `trig_up` while `trig_dn` is low, and a fall of `trig_dn` while `trig_up` is high do not trigger.
- R3: Take an input change set up before clock edge k. The resulting trigger sets `q[i]` at edge k+2. `q[i]` then stays high for exactly `pulse_len` cycles. Field i of `pulse_len` is bits [8*i+7 : 8*i].
- R4: A valid trigger while `q[i]` is high restarts the count, so `q[i]` falls `pulse_len` cycles after the last trigger sets it.
- R5: While `clr_n[i]` is held low, `q[i]` is low and no trigger edge has any effect on the outputs.
- R6: Pulling `clr_n[i]` low during a pulse ends the pulse three edges later, before the programmed width expires.
- R7: After `clr_n[i]` returns high, a trigger is dropped if its synchronized edge comes fewer than REC_CYC (default 4) cycles after the synchronized release. A trigger whose edge comes REC_CYC or more cycles after the release is accepted.
- R8: `q_n[i]` is always the inverse of `q[i]`. Activity on one channel never changes the other channel's outputs.
- R9: A `pulse_len` field of zero gives a one-cycle pulse.
- R10: While `rst` is high and after it falls, `q` is low. Triggers are blocked for the first max(REC_CYC,3) cycles after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both channels |
| rst | input | 1 | Synchronous active-high reset |
| trig_up | input | 2 | Rising-edge trigger line per channel |
| trig_dn | input | 2 | Falling-edge trigger line per channel |
| clr_n | input | 2 | Active-low clear per channel |
| pulse_len | input | 16 | Pulse width in cycles, 8 bits per channel |
| q | output | 2 | Pulse output per channel |
| q_n | output | 2 | Inverted pulse output per channel |

## Verification
The hardest case to reach from the ports is a trigger edge that lands exactly at the boundary of the recovery window after a clear. The window is counted on synchronized signals, so the stimulus releases clear and then raises the trigger line after a chosen number of cycles. One placement is one cycle too early and must be dropped. The next placement is exactly on time and must fire. A second sequence raises the trigger line on the same cycle as the clear release, and the bench checks that this edge is lost for good. A retrigger is placed so that the extended pulse is sampled beyond the point where the first pulse would have ended.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Synchronized control sample for one channel
    typedef struct packed {
        logic up;
        logic dn;
        logic clr_n;
    } ctl_t;

    // Idle levels: falling line parked high so the rising line is armed
    localparam ctl_t CTL_IDLE = '{up: 1'b0, dn: 1'b1, clr_n: 1'b1};

    typedef struct packed {
        logic fire;
        logic clear;
    } evt_t;

    // A programmed length of zero behaves as one cycle
    function automatic logic [7:0] eff_len(input logic [7:0] len);
        return (len == 8'd0) ? 8'd1 : len;
    endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync
    import oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t raw,
    output ctl_t cur,
    output ctl_t prev
);
    ctl_t meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= CTL_IDLE;
            cur  <= CTL_IDLE;
            prev <= CTL_IDLE;
        end else begin
            meta <= raw;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/os_gate.sv
module os_gate
    import oneshot_pkg::*;
#(
    parameter int REC_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t cur,
    input  ctl_t prev,
    output evt_t evt
);
    localparam int REC_INIT = (REC_CYC > 3) ? REC_CYC : 3;
    localparam int REC_W    = $clog2(REC_INIT + 1);

    logic [REC_W-1:0] rec_cnt;
    logic             up_edge;
    logic             dn_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_cnt <= REC_W'(REC_INIT);
        end else if (!cur.clr_n) begin
            rec_cnt <= REC_W'(REC_CYC);
        end else if (rec_cnt != '0) begin
            rec_cnt <= rec_cnt - 1'b1;
        end
    end

    always_comb begin
        up_edge   = cur.up && !prev.up && cur.dn;
        dn_edge   = !cur.dn && prev.dn && !cur.up;
        evt.clear = !cur.clr_n;
        evt.fire  = cur.clr_n && (rec_cnt == '0) && (up_edge || dn_edge);
    end
endmodule

// File: rtl/os_timer.sv
module os_timer
    import oneshot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  evt_t       evt,
    input  logic [7:0] len,
    output logic       q
);
    logic [7:0] remain;

    always_ff @(posedge clk) begin
        if (rst || evt.clear) begin
            q      <= 1'b0;
            remain <= '0;
        end else if (evt.fire) begin
            q      <= 1'b1;
            remain <= eff_len(len) - 8'd1;
        end else if (q) begin
            if (remain == '0) begin
                q <= 1'b0;
            end else begin
                remain <= remain - 8'd1;
            end
        end
    end
endmodule

// File: rtl/oneshot_dual.sv
module oneshot_dual
    import oneshot_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int REC_CYC = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CH-1:0]   trig_up,
    input  logic [NUM_CH-1:0]   trig_dn,
    input  logic [NUM_CH-1:0]   clr_n,
    input  logic [NUM_CH*8-1:0] pulse_len,
    output logic [NUM_CH-1:0]   q,
    output logic [NUM_CH-1:0]   q_n
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        ctl_t raw;
        ctl_t cur;
        ctl_t prev;
        evt_t evt;
        logic q_int;

        assign raw = '{up: trig_up[ch], dn: trig_dn[ch], clr_n: clr_n[ch]};

        os_sync u_sync (
            .clk (clk),
            .rst (rst),
            .raw (raw),
            .cur (cur),
            .prev(prev)
        );

        os_gate #(.REC_CYC(REC_CYC)) u_gate (
            .clk (clk),
            .rst (rst),
            .cur (cur),
            .prev(prev),
            .evt (evt)
        );

        os_timer u_timer (
            .clk(clk),
            .rst(rst),
            .evt(evt),
            .len(pulse_len[ch*8 +: 8]),
            .q  (q_int)
        );

        assign q[ch]   = q_int;
        assign q_n[ch] = ~q_int;
    end
endmodule

// File: rtl/oneshot_dual_chk.sv
module oneshot_dual_chk #(
    parameter int NUM_CH  = 2,
    parameter int REC_CYC = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] clr_n,
    input logic [NUM_CH-1:0] q,
    input logic [NUM_CH-1:0] q_n
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    always_ff @(posedge clk) begin
        if (rst_d && !rst) begin
            AST_IDLE_AFTER_RST: assert (q == '0) else $error("q not idle after reset"); // R10
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
            q_n[ch] == !q[ch]); // R8

        AST_CLEAR_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
            (!$past(clr_n[ch], 3) && !$past(clr_n[ch], 4)) |-> !q[ch]); // R5

        AST_RISE_NEEDS_CLEAR_HIGH: assert property (@(posedge clk) disable iff (rst)
            $rose(q[ch]) |-> $past(clr_n[ch], 3)); // R1

        if (REC_CYC >= 1) begin : g_rec
            AST_NO_RISE_IN_RECOVERY: assert property (@(posedge clk) disable iff (rst)
                $rose(q[ch]) |-> $past(clr_n[ch], 4)); // R7
        end
    end
endmodule

bind oneshot_dual oneshot_dual_chk #(.NUM_CH(NUM_CH), .REC_CYC(REC_CYC)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .clr_n(clr_n),
    .q    (q),
    .q_n  (q_n)
);

// File: tb/oneshot_dual_tb.sv
module oneshot_dual_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  trig_up = 2'b00;
    logic [1:0]  trig_dn = 2'b11;
    logic [1:0]  clr_n = 2'b11;
    logic [15:0] pulse_len = {8'd3, 8'd5};
    logic [1:0]  q;
    logic [1:0]  q_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    oneshot_dual u_dut (
        .clk(clk), .rst(rst), .trig_up(trig_up), .trig_dn(trig_dn),
        .clr_n(clr_n), .pulse_len(pulse_len), .q(q), .q_n(q_n)
    );

    // Row: {req[3:0], up, dn, clr_n, wait[4:0], expected q0}, channel 0, width 5
    localparam int NROW = 39;
    localparam logic [12:0] TBL [NROW] = '{
        {4'd1, 3'b111, 5'd2,  1'b0},  // R1 not yet visible
        {4'd1, 3'b111, 5'd1,  1'b1},  // R1 visible after third edge
        {4'd3, 3'b111, 5'd4,  1'b1},  // R3 last high cycle
        {4'd3, 3'b111, 5'd1,  1'b0},  // R3 ends after 5 cycles
        {4'd2, 3'b011, 5'd8,  1'b0},  // R2 up falling: no trigger
        {4'd2, 3'b001, 5'd3,  1'b1},  // R2 dn falling with up low
        {4'd3, 3'b001, 5'd5,  1'b0},  // R3 ends
        {4'd2, 3'b011, 5'd8,  1'b0},  // R2 dn rising: no trigger
        {4'd1, 3'b111, 5'd10, 1'b0},  // R1 trigger, long expired
        {4'd2, 3'b101, 5'd8,  1'b0},  // R2 dn falls while up high
        {4'd2, 3'b001, 5'd8,  1'b0},  // R2 up falls
        {4'd1, 3'b101, 5'd8,  1'b0},  // R1 up rises while dn low
        {4'd2, 3'b001, 5'd1,  1'b0},  // R2 up falls
        {4'd2, 3'b011, 5'd8,  1'b0},  // R2 dn rises
        {4'd4, 3'b111, 5'd3,  1'b1},  // R4 first trigger
        {4'd4, 3'b011, 5'd1,  1'b1},  // R4
        {4'd4, 3'b111, 5'd6,  1'b1},  // R4 retrigger, past first end
        {4'd4, 3'b111, 5'd1,  1'b1},  // R4 last high
        {4'd4, 3'b111, 5'd1,  1'b0},  // R4 ends
        {4'd4, 3'b011, 5'd8,  1'b0},  // R4 idle
        {4'd6, 3'b111, 5'd3,  1'b1},  // R6 pulse starts
        {4'd6, 3'b110, 5'd2,  1'b1},  // R6 clear not yet effective
        {4'd6, 3'b110, 5'd1,  1'b0},  // R6 cut short
        {4'd5, 3'b010, 5'd4,  1'b0},  // R5
        {4'd5, 3'b110, 5'd4,  1'b0},  // R5 trigger ignored under clear
        {4'd5, 3'b010, 5'd4,  1'b0},  // R5
        {4'd7, 3'b111, 5'd8,  1'b0},  // R7 release and edge together: dropped
        {4'd7, 3'b011, 5'd2,  1'b0},  // R7
        {4'd7, 3'b111, 5'd3,  1'b1},  // R7 recovered
        {4'd7, 3'b011, 5'd8,  1'b0},  // R7
        {4'd7, 3'b010, 5'd4,  1'b0},  // R7 clear
        {4'd7, 3'b011, 5'd3,  1'b0},  // R7 release
        {4'd7, 3'b111, 5'd8,  1'b0},  // R7 edge one cycle early: dropped
        {4'd7, 3'b011, 5'd4,  1'b0},  // R7
        {4'd7, 3'b010, 5'd4,  1'b0},  // R7 clear
        {4'd7, 3'b011, 5'd4,  1'b0},  // R7 release
        {4'd7, 3'b111, 5'd3,  1'b1},  // R7 edge exactly at window end
        {4'd7, 3'b111, 5'd5,  1'b0},  // R7 full width
        {4'd7, 3'b011, 5'd4,  1'b0}   // R7 idle
    };

    task automatic chk(input int req, input logic got, input logic exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_n(4);
        chk(10, q[0], 1'b0, "R10 q0 during reset");
        chk(10, q_n[0], 1'b1, "R10 qn0 during reset");
        chk(10, q[1], 1'b0, "R10 q1 during reset");
        rst = 1'b0;
        wait_n(10);
        chk(10, q[0], 1'b0, "R10 q0 idle after reset");

        for (int r = 0; r < NROW; r++) begin
            trig_up[0] = TBL[r][8];
            trig_dn[0] = TBL[r][7];
            clr_n[0]   = TBL[r][6];
            wait_n(int'(TBL[r][5:1]));
            chk(int'(TBL[r][12:9]), q[0], TBL[r][0], $sformatf("row %0d q0", r));
            chk(8, q_n[0], ~TBL[r][0], $sformatf("R8 row %0d q_n0", r));
            chk(8, q[1], 1'b0, $sformatf("R8 row %0d ch1 undisturbed", r));
        end

        // R8 channel 1 with width 3 while channel 0 is held in clear
        clr_n[0] = 1'b0;
        trig_up[1] = 1'b1;
        wait_n(3);
        chk(8, q[1], 1'b1, "R8 ch1 fires during ch0 clear");
        chk(8, q[0], 1'b0, "R8 ch0 stays low");
        wait_n(2);
        chk(3, q[1], 1'b1, "R3 ch1 last high");
        wait_n(1);
        chk(3, q[1], 1'b0, "R3 ch1 ends after 3");
        chk(8, q_n[1], 1'b1, "R8 q_n1");

        // R9 zero length gives one cycle
        trig_up[1] = 1'b0;
        pulse_len[15:8] = 8'd0;
        wait_n(4);
        trig_up[1] = 1'b1;
        wait_n(3);
        chk(9, q[1], 1'b1, "R9 zero length high");
        wait_n(1);
        chk(9, q[1], 1'b0, "R9 zero length one cycle");

        // R10 reset mid-pulse and blocked start-up edges
        clr_n[0] = 1'b1;
        trig_up[1] = 1'b0;
        pulse_len[15:8] = 8'd20;
        wait_n(10);
        trig_up[1] = 1'b1;
        wait_n(4);
        chk(10, q[1], 1'b1, "R10 pulse before reset");
        rst = 1'b1;
        wait_n(1);
        chk(10, q[1], 1'b0, "R10 reset clears pulse");
        trig_up[1] = 1'b0;
        wait_n(3);
        trig_up[1] = 1'b1;
        rst = 1'b0;
        wait_n(8);
        chk(10, q[1], 1'b0, "R10 edge right after reset blocked");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                wait_n(5000);
                bad++;
                total++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule